// File: doc/BRIEF.md
# SMRAM Window Decode and Redirect

This block sits in the memory controller, next to the processor bus. Each address strobe carries a physical address, and the block steers that access to one of two chip selects: the SMRAM array or ordinary system RAM. Its inputs for that choice are the address, whether the processor reports that it is in system management mode, whether a non-processor master (DMA or another bus master) owns the cycle, and a software-held manual open bit. The SMRAM window is given by a base address and a power-of-two size, from 32 KB up to the whole 4 GB space. A base of 38000h with a 32 KB size gives the smallest useful window, 38000h through 3FFFFh. The handler entry is the window base. The processor save image lies in the top 512 bytes of the first 32 KB of the window, which is 3FE00h through 3FFFFh for that smallest window.

A three-state mode machine decides who may reach the window:

- **CLOSED**: nobody.
- **OPEN**: any master. Software uses this mode to load the handler while the processor is outside SMM.
- **SMM**: only the processor.

The mode machine has these transitions:

- CLOSED→SMM and OPEN→SMM when the SMM-active input is seen high.
- CLOSED→OPEN when manual open is seen high and SMM-active is low.
- OPEN→CLOSED when manual open drops.
- SMM→OPEN when SMM-active falls while manual open is high.
- SMM→CLOSED when SMM-active falls while manual open is low.

Chip selects and the save-area flag are registered. They appear one clock after the strobe and are decided by the mode that the sampled inputs select.

Some systems overlay SMRAM on normal memory. For those, the block raises a cache flush request combinationally, in the same clock as the incoming SMI pulse. It does this only while the mode machine is not already in SMM.

Top module: `smram_redirect`

## Requirements
- R1: With no address strobe in a cycle, neither chip select is high in the following cycle. With a strobe, exactly one of them is high in the following cycle. During reset both are low.
- R2: An access is in the window when its address lies in [base, base + 2^k), where k is the size input (15 ≤ k ≤ 32, with k = 32 covering all 4 GB). Addresses outside the window always select system RAM.
- R3: With SMM-active high, a processor access (alternate-master input low) in the window selects SMRAM.
- R4: With SMM-active high, an alternate-master access in the window selects system RAM.
- R5: With SMM-active low and manual open high, any master's access in the window selects SMRAM.
- R6: Manual open has no effect while SMM-active is high. An alternate master still goes to system RAM, and a processor access still goes to SMRAM.
- R7: With SMM-active low and manual open low, every access selects system RAM.
- R8: The config-error output is high, combinationally, when k is outside 15..32 or when the base has any bit set below bit k. While it is high, every access selects system RAM.
- R9: The flush request is high in the same cycle as the SMI pulse when overlay mode is enabled and SMM-active was low at the previous clock edge. It is low otherwise.
- R10: The save-area flag rises together with the SMRAM select when the offset into the window lies in 7E00h..7FFFh. It is low for every other access.
- R11: When SMM-active falls while manual open is held high, the very next access uses open-mode routing. An alternate master in the window then reaches SMRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | input | 32 | Physical address of the access |
| addr_valid | input | 1 | Address strobe for this cycle |
| smm_active | input | 1 | Processor reports it is in SMM |
| alt_master | input | 1 | Cycle is owned by DMA or another bus master |
| manual_open | input | 1 | Software bit that opens the window outside SMM |
| win_base | input | 32 | SMRAM window base address |
| win_size_log2 | input | 6 | log2 of window size in bytes |
| overlay_en | input | 1 | SMRAM overlays normal memory |
| smi_pulse | input | 1 | SMI request seen this cycle |
| sel_smram | output | 1 | SMRAM chip select (registered) |
| sel_sysram | output | 1 | System RAM chip select (registered) |
| save_area_hit | output | 1 | Access hits the state save area (registered) |
| cfg_error | output | 1 | Window base/size configuration invalid |
| flush_req | output | 1 | Cache flush request, same clock as SMI |

## Verification
The bench keeps the defaults: a 32-bit address and a minimum size of 32 KB. It reprograms the window at run time through the base and size inputs. It walks the 38000h window and its edges, a misaligned base, a size below the minimum, a 1 MB window at 100000h, and the k = 32 window that spans the whole address space. With the full address width in place, the top-of-space address and the mask edge case at k = 32 are both reachable, and the save-area offset is checked in windows of more than one size.

// File: rtl/smram_pkg.sv
package smram_pkg;

    typedef enum logic [1:0] {
        MODE_CLOSED = 2'd0,
        MODE_OPEN   = 2'd1,
        MODE_SMM    = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        ROUTE_NONE  = 2'd0,
        ROUTE_SYS   = 2'd1,
        ROUTE_SMRAM = 2'd2
    } route_e;

endpackage

// File: rtl/smram_window_cfg.sv
module smram_window_cfg #(
    parameter int AW        = 32,
    parameter int LW        = 6,
    parameter int MIN_LOG2  = 15,
    parameter int SEG_LOG2  = 15,
    parameter int SAVE_LOG2 = 9
) (
    input  logic [AW-1:0] mem_addr,
    input  logic [AW-1:0] win_base,
    input  logic [LW-1:0] win_size_log2,
    output logic          cfg_error,
    output logic          in_window,
    output logic          in_save
);

    localparam logic [AW-1:0] SAVE_LO = AW'((64'd1 << SEG_LOG2) - (64'd1 << SAVE_LOG2));
    localparam logic [AW-1:0] SAVE_HI = AW'((64'd1 << SEG_LOG2) - 64'd1);

    logic          size_bad;
    logic          base_bad;
    logic [AW:0]   span;
    logic [AW:0]   low_mask;
    logic [AW-1:0] keep_mask;
    logic [AW-1:0] offset;

    always_comb begin
        size_bad  = (win_size_log2 < LW'(MIN_LOG2)) || (win_size_log2 > LW'(AW));
        span      = size_bad ? '0 : ((AW+1)'(1) << win_size_log2);
        low_mask  = span - (AW+1)'(1);
        keep_mask = ~low_mask[AW-1:0];
        base_bad  = |(win_base & low_mask[AW-1:0]);
        cfg_error = size_bad | base_bad;
        offset    = mem_addr & low_mask[AW-1:0];
        in_window = !cfg_error && ((mem_addr & keep_mask) == (win_base & keep_mask));
        in_save   = in_window && (offset >= SAVE_LO) && (offset <= SAVE_HI);
    end

endmodule

// File: rtl/smram_mode_fsm.sv
module smram_mode_fsm
    import smram_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  smm_active,
    input  logic  manual_open,
    input  logic  overlay_en,
    input  logic  smi_pulse,
    output mode_e mode_now,
    output logic  flush_req
);

    mode_e state_q;
    mode_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_CLOSED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_CLOSED: begin
                if (smm_active)       state_d = MODE_SMM;
                else if (manual_open) state_d = MODE_OPEN;
            end
            MODE_OPEN: begin
                if (smm_active)        state_d = MODE_SMM;
                else if (!manual_open) state_d = MODE_CLOSED;
            end
            MODE_SMM: begin
                if (!smm_active) state_d = manual_open ? MODE_OPEN : MODE_CLOSED;
            end
            default: state_d = MODE_CLOSED;
        endcase
    end

    always_comb begin
        mode_now  = state_d;
        flush_req = overlay_en && smi_pulse && (state_q != MODE_SMM);
    end

    // R9: a flush request only ever accompanies an SMI on an overlaid system
    p_flush_needs_smi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> (smi_pulse && overlay_en));

    // R9: no flush while SMM was already active at the last edge
    p_no_flush_in_smm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(smm_active) |-> !flush_req);

    // R6: SMM-active wins over manual open in the mode register
    p_smm_follows_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        smm_active |=> (state_q == MODE_SMM));

endmodule

// File: rtl/smram_route.sv
module smram_route
    import smram_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  addr_valid,
    input  logic  alt_master,
    input  logic  in_window,
    input  logic  in_save,
    input  mode_e mode,
    output logic  sel_smram,
    output logic  sel_sysram,
    output logic  save_area_hit
);

    route_e route_d;

    always_comb begin
        route_d = ROUTE_NONE;
        if (addr_valid) begin
            route_d = ROUTE_SYS;
            if (in_window) begin
                unique case (mode)
                    MODE_SMM:    route_d = alt_master ? ROUTE_SYS : ROUTE_SMRAM;
                    MODE_OPEN:   route_d = ROUTE_SMRAM;
                    MODE_CLOSED: route_d = ROUTE_SYS;
                    default:     route_d = ROUTE_SYS;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_smram     <= 1'b0;
            sel_sysram    <= 1'b0;
            save_area_hit <= 1'b0;
        end else begin
            sel_smram     <= (route_d == ROUTE_SMRAM);
            sel_sysram    <= (route_d == ROUTE_SYS);
            save_area_hit <= (route_d == ROUTE_SMRAM) && in_save;
        end
    end

    // R1: a strobe yields exactly one select on the next cycle
    p_one_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(addr_valid) && $past(rst_n)) |-> ($countones({sel_smram, sel_sysram}) == 1));

    // R1: no strobe, no select
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(addr_valid) |-> !(sel_smram || sel_sysram));

    // R4: an alternate master never reaches SMRAM during SMM
    p_alt_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(addr_valid && alt_master && (mode == MODE_SMM)) |-> !sel_smram);

    // R10: the save flag never stands alone
    p_save_inside_r10: assert property (@(posedge clk) disable iff (!rst_n)
        save_area_hit |-> sel_smram);

endmodule

// File: rtl/smram_redirect.sv
module smram_redirect
    import smram_pkg::*;
#(
    parameter  int AW        = 32,
    parameter  int MIN_LOG2  = 15,
    parameter  int SEG_LOG2  = 15,
    parameter  int SAVE_LOG2 = 9,
    localparam int LW        = $clog2(AW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] mem_addr,
    input  logic          addr_valid,
    input  logic          smm_active,
    input  logic          alt_master,
    input  logic          manual_open,
    input  logic [AW-1:0] win_base,
    input  logic [LW-1:0] win_size_log2,
    input  logic          overlay_en,
    input  logic          smi_pulse,
    output logic          sel_smram,
    output logic          sel_sysram,
    output logic          save_area_hit,
    output logic          cfg_error,
    output logic          flush_req
);

    logic  in_window;
    logic  in_save;
    mode_e mode_now;

    smram_window_cfg #(
        .AW        (AW),
        .LW        (LW),
        .MIN_LOG2  (MIN_LOG2),
        .SEG_LOG2  (SEG_LOG2),
        .SAVE_LOG2 (SAVE_LOG2)
    ) u_cfg (
        .mem_addr      (mem_addr),
        .win_base      (win_base),
        .win_size_log2 (win_size_log2),
        .cfg_error     (cfg_error),
        .in_window     (in_window),
        .in_save       (in_save)
    );

    smram_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .smm_active  (smm_active),
        .manual_open (manual_open),
        .overlay_en  (overlay_en),
        .smi_pulse   (smi_pulse),
        .mode_now    (mode_now),
        .flush_req   (flush_req)
    );

    smram_route u_route (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr_valid    (addr_valid),
        .alt_master    (alt_master),
        .in_window     (in_window),
        .in_save       (in_save),
        .mode          (mode_now),
        .sel_smram     (sel_smram),
        .sel_sysram    (sel_sysram),
        .save_area_hit (save_area_hit)
    );

    // R8: a bad configuration keeps every access away from SMRAM
    p_cfg_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_error && addr_valid) && $past(rst_n)) |-> !sel_smram);

    // R7: closed window with no SMM sends everything to system RAM
    p_closed_sys_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(addr_valid && !smm_active && !manual_open) |-> !sel_smram);

endmodule

// File: tb/smram_redirect_tb.sv
`timescale 1ns/1ps
module smram_redirect_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr = '0;
    logic        addr_valid = 1'b0;
    logic        smm_active = 1'b0;
    logic        alt_master = 1'b0;
    logic        manual_open = 1'b0;
    logic [31:0] win_base = 32'h0003_8000;
    logic [5:0]  win_size_log2 = 6'd15;
    logic        overlay_en = 1'b1;
    logic        smi_pulse = 1'b0;
    logic        sel_smram, sel_sysram, save_area_hit, cfg_error, flush_req;

    smram_redirect u_dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .addr_valid(addr_valid),
        .smm_active(smm_active), .alt_master(alt_master), .manual_open(manual_open),
        .win_base(win_base), .win_size_log2(win_size_log2), .overlay_en(overlay_en),
        .smi_pulse(smi_pulse), .sel_smram(sel_smram), .sel_sysram(sel_sysram),
        .save_area_hit(save_area_hit), .cfg_error(cfg_error), .flush_req(flush_req)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic  sm;
        logic  sys;
        logic  save;
        string req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    logic prev_smm = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) prev_smm <= 1'b0;
        else        prev_smm <= smm_active;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic model_cfg_bad();
        longint span;
        if (win_size_log2 < 6'd15 || win_size_log2 > 6'd32) return 1'b1;
        span = longint'(1) << win_size_log2;
        return (longint'({32'd0, win_base}) % span) != 0;
    endfunction

    function automatic logic model_in_win(input logic [31:0] a);
        longint span;
        longint b;
        if (model_cfg_bad()) return 1'b0;
        span = longint'(1) << win_size_log2;
        b    = longint'({32'd0, win_base});
        return (longint'({32'd0, a}) >= b) && (longint'({32'd0, a}) < b + span);
    endfunction

    task automatic issue(input logic [31:0] a, input logic v, input logic ext,
                         input logic act, input logic op, input string req);
        exp_t   e;
        longint off;
        @(negedge clk);
        mem_addr = a; addr_valid = v; alt_master = ext;
        smm_active = act; manual_open = op;
        e.sm   = v && model_in_win(a) && ((act && !ext) || (!act && op));
        e.sys  = v && !e.sm;
        off    = longint'({32'd0, a}) - longint'({32'd0, win_base});
        e.save = e.sm && (off >= 64'h7E00) && (off <= 64'h7FFF);
        e.req  = req;
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            check(e.req, "sel_smram", {31'd0, sel_smram}, {31'd0, e.sm});
            check(e.req, "sel_sysram", {31'd0, sel_sysram}, {31'd0, e.sys});
            check(e.req, "save_area_hit", {31'd0, save_area_hit}, {31'd0, e.save});
        end
    end

    task automatic set_cfg(input logic [31:0] b, input logic [5:0] k, input string req);
        @(negedge clk);
        win_base = b; win_size_log2 = k; addr_valid = 1'b0;
        #1;
        check(req, "cfg_error", {31'd0, cfg_error}, {31'd0, model_cfg_bad()});
    endtask

    task automatic pulse_smi(input logic ovl, input string req);
        @(negedge clk);
        overlay_en = ovl; smi_pulse = 1'b1;
        #1;
        check(req, "flush_req", {31'd0, flush_req}, {31'd0, (ovl && !prev_smm)});
        #0.5;
        smi_pulse = 1'b0;
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset sel_smram", {31'd0, sel_smram}, 32'd0);
        check("R1", "reset sel_sysram", {31'd0, sel_sysram}, 32'd0);
        check("R1", "reset save_area_hit", {31'd0, save_area_hit}, 32'd0);
        check("R9", "reset flush_req", {31'd0, flush_req}, 32'd0);
        rst_n = 1'b1;

        set_cfg(32'h0003_8000, 6'd15, "R8");
        issue(32'h0003_8000, 0, 0, 0, 0, "R1");
        // SMM processor traffic on the minimum window
        issue(32'h0003_8000, 1, 0, 1, 0, "R3");
        issue(32'h0003_FE00, 1, 0, 1, 0, "R10");
        issue(32'h0003_FFFF, 1, 0, 1, 0, "R10");
        issue(32'h0003_FDFF, 1, 0, 1, 0, "R10");
        issue(32'h0004_0000, 1, 0, 1, 0, "R2");
        issue(32'h0003_7FFF, 1, 0, 1, 0, "R2");
        issue(32'h0003_8000, 1, 1, 1, 0, "R4");
        issue(32'h0003_9000, 1, 1, 1, 1, "R6");
        issue(32'h0003_9000, 1, 0, 1, 1, "R6");
        issue(32'h0003_9000, 0, 0, 1, 0, "R1");
        pulse_smi(1'b1, "R9");
        issue(32'h0000_0000, 0, 0, 0, 0, "R1");
        pulse_smi(1'b1, "R9");
        pulse_smi(1'b0, "R9");
        overlay_en = 1'b1;
        // window closed, then opened by software
        issue(32'h0003_8000, 1, 0, 0, 0, "R7");
        issue(32'h0003_C000, 1, 1, 0, 0, "R7");
        issue(32'h0003_8000, 1, 0, 0, 1, "R5");
        issue(32'h0003_C000, 1, 1, 0, 1, "R5");
        issue(32'h0004_0000, 1, 0, 0, 1, "R2");
        // leaving SMM with manual open held
        issue(32'h0003_A000, 1, 1, 1, 1, "R6");
        issue(32'h0003_A000, 1, 1, 0, 1, "R11");
        issue(32'h0003_A000, 0, 0, 0, 0, "R1");
        // bad configurations
        set_cfg(32'h0003_8100, 6'd15, "R8");
        issue(32'h0003_8100, 1, 0, 0, 1, "R8");
        issue(32'h0003_8100, 1, 0, 1, 0, "R8");
        set_cfg(32'h0003_8000, 6'd14, "R8");
        issue(32'h0003_8000, 1, 0, 1, 0, "R8");
        // whole-space window
        set_cfg(32'h0000_0000, 6'd32, "R2");
        issue(32'hFFFF_0000, 1, 0, 1, 0, "R2");
        issue(32'h0000_7E00, 1, 0, 1, 0, "R10");
        // 1 MB window
        set_cfg(32'h0010_0000, 6'd20, "R2");
        issue(32'h001F_FFFF, 1, 0, 1, 0, "R2");
        issue(32'h0010_7E10, 1, 0, 1, 0, "R10");
        issue(32'h0020_0000, 1, 0, 1, 0, "R2");
        issue(32'h000F_FFFF, 1, 0, 0, 1, "R2");
        issue(32'h0000_0000, 0, 0, 0, 0, "R1");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule